// File: doc/BRIEF.md
# External Data Bus Cycle Sequencer

This block runs one external data-memory access on a bus where the low address byte and the data byte share the same eight wires. A caller raises a request with a 16-bit address, a direction flag and, for a write, a data byte. The block then plays out a fixed twelve-period machine cycle. It emits an address-latch strobe, a read or write strobe (both active low), the shared address/data byte with an output enable, and the upper address byte. One clock of the block equals one oscillator period, and every edge falls on a fixed period offset from the latch strobe.

On a read the shared byte is released before the read strobe goes low. The incoming byte is captured at the moment the read strobe returns high. On a write the data byte is driven from one period before the write strobe falls until one period after it rises. A `busy` flag covers the whole cycle. `done` pulses in the last period, and requests presented while busy are dropped.

Top module: `xbus_seq`

## Requirements
- R1: While `rst_n` is low and after reset with no request: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `busy`=0, `done`=0.
- R2: A request sampled while idle starts a cycle on the next clock. The cycle has twelve periods, numbered 0 to 11. `ale` is 1 in periods 0 and 1 only, and is never 1 while a strobe is low.
- R3: The strobe falls 3 periods after `ale` falls (period 5) and stays low for exactly 6 periods (periods 5 to 10). `rd_n` is used when `req_write`=0 and `wr_n` when `req_write`=1; the other strobe stays at 1.
- R4: `ad_oe`=1 and `ad_out`=address bits 7:0 in periods 0 to 3. The low address therefore stays on the bus 2 periods after `ale` falls and is valid 4 or more periods before the strobe falls.
- R5: On a write, `ad_oe`=1 and `ad_out`=write data in periods 4 to 11. That is 1 period before `wr_n` falls, 7 periods of setup before it rises, and 1 period of hold after it rises.
- R6: On a read, `ad_oe`=0 from period 4 to the end of the cycle, which covers every period in which `rd_n` is low.
- R7: On a read, `rdata` takes the value of `ad_in` in period 10, the last period with `rd_n` low. The value shows from period 11 on. Later changes of `ad_in` and later write cycles leave `rdata` unchanged.
- R8: `a_hi` equals address bits 15:8 through all twelve periods and keeps that value while idle.
- R9: `busy`=1 in periods 0 to 11. `done`=1 in period 11 only, for a single clock.
- R10: A request presented while `busy`=1 is ignored. `a_hi` and the cycle timing are unaffected, and no new cycle starts when the current one ends unless `req_valid` is still high once `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data byte |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse in the final period |
| rdata | output | 8 | Captured read byte |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Shared low-address/data byte, driven value |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 8 | Shared byte as seen from the pads |
| a_hi | output | 8 | Upper address byte |

## Verification
All outputs are decoded from registered state, so period 0 is visible one clock after the edge that samples the request, and period k is visible k clocks later. The bench samples on falling edges. It records each of the twelve periods of a cycle and compares each one against the period table in the requirements. From the same trace it measures the edge offsets: the `ale` fall, the strobe fall and rise, and the data-enable window. Read data is presented only in the strobe-low window and is changed in period 11, after the capture edge, so `rdata` is checked from period 11 onward. Ignored requests are checked by watching `a_hi`, `busy` and `ale` for several clocks after the cycle ends.

// File: rtl/xbus_pkg.sv
// Shared definitions for the external data bus sequencer.
// Holds the access direction type and default timing, in oscillator periods.
package xbus_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } xbus_op_e;

    localparam int XB_ADDR_W     = 16;
    localparam int XB_DATA_W     = 8;
    localparam int XB_ALE_LEN    = 2;  // periods the latch strobe is high
    localparam int XB_ADDR_HOLD  = 2;  // address kept after latch strobe falls
    localparam int XB_STROBE_DLY = 3;  // latch fall to strobe fall
    localparam int XB_STROBE_LEN = 6;  // strobe low width
    localparam int XB_WDATA_LEAD = 1;  // write data ahead of strobe fall
    localparam int XB_WDATA_HOLD = 1;  // write data after strobe rise
    localparam int XB_ALE_GAP    = 1;  // strobe rise to next latch strobe

endpackage

// File: rtl/xbus_timer.sv
// Period counter for one bus cycle.
// Starts on 'start' while idle, counts CYC_LEN periods, then returns idle.
// Assumes 'start' is ignored while a cycle runs.
module xbus_timer #(
    parameter int CYC_LEN = 12,
    localparam int PH_W   = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            active,
    output logic [PH_W-1:0] phase,
    output logic            last
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

    // Advance the period count and track whether a cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                phase  <= '0;
            end
        end else if (phase == LAST_PH) begin
            active <= 1'b0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Flag the final period of the cycle.
    always_comb last = active && (phase == LAST_PH);

endmodule

// File: rtl/xbus_phase_dec.sv
// Turns the current period number into bus control levels.
// Every output is a pure decode of registered state, so it changes only at clock edges.
// Assumes the window parameters satisfy ADDR_END <= STRB_ON and WD_OFF <= CYC_LEN.
module xbus_phase_dec
    import xbus_pkg::*;
#(
    parameter int CYC_LEN  = 12,
    parameter int ALE_LEN  = 2,
    parameter int ADDR_END = 4,
    parameter int STRB_ON  = 5,
    parameter int STRB_OFF = 11,
    parameter int WD_ON    = 4,
    parameter int WD_OFF   = 12,
    localparam int PH_W    = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            active,
    input  logic [PH_W-1:0] phase,
    input  xbus_op_e        op,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic            addr_drv,
    output logic            data_drv,
    output logic            capture
);

    int  ph;
    logic strb;

    // Decode period windows into strobe and drive levels.
    always_comb begin
        ph       = int'(phase);
        ale      = active && (ph < ALE_LEN);
        strb     = active && (ph >= STRB_ON) && (ph < STRB_OFF);
        rd_n     = !(strb && (op == OP_READ));
        wr_n     = !(strb && (op == OP_WRITE));
        addr_drv = active && (ph < ADDR_END);
        data_drv = active && (op == OP_WRITE) && (ph >= WD_ON) && (ph < WD_OFF);
        capture  = active && (op == OP_READ) && (ph == STRB_OFF - 1);
    end

endmodule

// File: rtl/xbus_datapath.sv
// Request holding registers, shared-byte multiplexer and read capture.
// Loads the request on 'load'. Captures 'ad_in' on the clock edge that ends
// the last strobe-low period, which is the edge where the read strobe rises.
module xbus_datapath
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                addr_drv,
    input  logic                data_drv,
    input  logic                capture,
    input  logic [DATA_W-1:0]   ad_in,
    output xbus_op_e            op,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]   rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Hold the request fields for the length of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            op      <= OP_READ;
        end else if (load) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            op      <= req_write ? OP_WRITE : OP_READ;
        end
    end

    // Capture the read byte as the read strobe returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= ad_in;
        end
    end

    // Choose the byte placed on the shared wires and its enable.
    always_comb begin
        ad_out = addr_drv ? addr_q[DATA_W-1:0] : wdata_q;
        ad_oe  = addr_drv || data_drv;
        a_hi   = addr_q[ADDR_W-1:DATA_W];
    end

endmodule

// File: rtl/xbus_seq.sv
// External data bus cycle sequencer, top level.
// Accepts one request while idle and plays a fixed machine cycle of
// CYC_LEN oscillator periods on a multiplexed address/data bus.
// Assumes clk runs at the oscillator period and the request is held until sampled.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W     = XB_ADDR_W,
    parameter int DATA_W     = XB_DATA_W,
    parameter int ALE_LEN    = XB_ALE_LEN,
    parameter int ADDR_HOLD  = XB_ADDR_HOLD,
    parameter int STROBE_DLY = XB_STROBE_DLY,
    parameter int STROBE_LEN = XB_STROBE_LEN,
    parameter int WDATA_LEAD = XB_WDATA_LEAD,
    parameter int WDATA_HOLD = XB_WDATA_HOLD,
    parameter int ALE_GAP    = XB_ALE_GAP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi
);

    localparam int STRB_ON  = ALE_LEN + STROBE_DLY;
    localparam int STRB_OFF = STRB_ON + STROBE_LEN;
    localparam int ADDR_END = ALE_LEN + ADDR_HOLD;
    localparam int WD_ON    = STRB_ON - WDATA_LEAD;
    localparam int WD_OFF   = STRB_OFF + WDATA_HOLD;
    localparam int CYC_LEN  = STRB_OFF + ALE_GAP;
    localparam int PH_W     = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

    logic            active;
    logic            last;
    logic            start;
    logic [PH_W-1:0] phase;
    logic            addr_drv;
    logic            data_drv;
    logic            capture;
    xbus_op_e        op;

    // Accept a request only while no cycle is running.
    always_comb begin
        start = req_valid && !active;
        busy  = active;
        done  = last;
    end

    xbus_timer #(.CYC_LEN(CYC_LEN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (active),
        .phase  (phase),
        .last   (last)
    );

    xbus_phase_dec #(
        .CYC_LEN  (CYC_LEN),
        .ALE_LEN  (ALE_LEN),
        .ADDR_END (ADDR_END),
        .STRB_ON  (STRB_ON),
        .STRB_OFF (STRB_OFF),
        .WD_ON    (WD_ON),
        .WD_OFF   (WD_OFF)
    ) u_dec (
        .active   (active),
        .phase    (phase),
        .op       (op),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr_drv (addr_drv),
        .data_drv (data_drv),
        .capture  (capture)
    );

    xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .addr_drv  (addr_drv),
        .data_drv  (data_drv),
        .capture   (capture),
        .ad_in     (ad_in),
        .op        (op),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi),
        .rdata     (rdata)
    );

endmodule

// File: rtl/xbus_seq_chk.sv
// Protocol checker for xbus_seq, attached by bind.
// Measures strobe offsets with counters rather than long delays.
module xbus_seq_chk #(
    parameter int STROBE_DLY = 3,
    parameter int STROBE_LEN = 6,
    parameter int HI_W       = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ad_oe,
    input logic [HI_W-1:0] a_hi
);

    logic [7:0] since_ale;
    logic [7:0] low_cnt;

    // Count periods since the latch strobe was last high.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_ale <= '0;
        else if (ale)                since_ale <= '0;
        else if (since_ale != 8'hFF) since_ale <= since_ale + 1'b1;
    end

    // Count consecutive periods with a strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)             low_cnt <= '0;
        else if (!rd_n || !wr_n) low_cnt <= low_cnt + 1'b1;
        else                     low_cnt <= '0;
    end

    p_strobe_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> (since_ale == 8'(STROBE_DLY)));

    p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> (low_cnt == 8'(STROBE_LEN)));

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_ahi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(a_hi));

    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !ale));

endmodule

bind xbus_seq xbus_seq_chk #(
    .STROBE_DLY (STROBE_DLY),
    .STROBE_LEN (STROBE_LEN),
    .HI_W       (ADDR_W - DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .ale   (ale),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .ad_oe (ad_oe),
    .a_hi  (a_hi)
);

// File: tb/sim_xbus_seq.sv
// Directed bench for xbus_seq: one task per scenario, each checking its own results.
module sim_xbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, ale, rd_n, wr_n, ad_oe;
    logic [7:0]  rdata, ad_out, a_hi;
    logic [7:0]  ad_in = '0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    xbus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: reset state, during and after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ale == 0 && rd_n && wr_n, "R1 strobes in reset", {ale, rd_n, wr_n}, 3'b011);
        chk(!ad_oe && !busy && !done, "R1 status in reset", {ad_oe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ale == 0 && rd_n && wr_n && !ad_oe && !busy && !done,
            "R1 idle after reset", {ale, rd_n, wr_n, ad_oe, busy, done}, 6'b011000);
    endtask

    // One full cycle; records twelve periods and checks them against R2..R10.
    task automatic t_cycle(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] rv, input bit poke);
        bit a_ale[12], a_rd[12], a_wr[12], a_oe[12];
        int fall_ale, fall_st, rise_st, oe_last;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        ad_in = ~rv;
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            a_ale[p] = ale; a_rd[p] = rd_n; a_wr[p] = wr_n; a_oe[p] = ad_oe;
            chk(ale == (p < 2), "R2 ale level", ale, (p < 2));
            chk((wr ? rd_n : wr_n) == 1'b1, "R3 unused strobe high", 0, 1);
            chk((wr ? wr_n : rd_n) == !(p >= 5 && p <= 10), "R3 strobe level",
                wr ? wr_n : rd_n, !(p >= 5 && p <= 10));
            if (p < 4) begin
                chk(ad_oe && ad_out == addr[7:0], "R4 low address on bus",
                    {ad_oe, ad_out}, {1'b1, addr[7:0]});
            end else if (wr) begin
                chk(ad_oe && ad_out == wd, "R5 write data on bus",
                    {ad_oe, ad_out}, {1'b1, wd});
            end else begin
                chk(!ad_oe, "R6 bus floated on read", ad_oe, 0);
            end
            chk(a_hi == addr[15:8], "R8 high address", a_hi, addr[15:8]);
            chk(busy && done == (p == 11), "R9 busy/done", {busy, done}, {1'b1, p == 11});
            if (p == 0) req_valid = 1'b0;
            if (poke && p == 3) begin
                req_valid = 1'b1; req_addr = ~addr; req_write = ~wr;
            end
            if (poke && p == 4) req_valid = 1'b0;
            if (!wr && p == 5) ad_in = rv;
            if (!wr && p == 11) begin
                chk(rdata == rv, "R7 read data captured", rdata, rv);
                ad_in = rv ^ 8'h5A;
            end
        end
        // Edge offsets measured from the trace.
        fall_ale = -1; fall_st = -1; rise_st = -1; oe_last = -1;
        for (int p = 1; p < 12; p++) begin
            if (a_ale[p-1] && !a_ale[p]) fall_ale = p;
            if ((wr ? a_wr[p-1] : a_rd[p-1]) && !(wr ? a_wr[p] : a_rd[p])) fall_st = p;
            if (!(wr ? a_wr[p-1] : a_rd[p-1]) && (wr ? a_wr[p] : a_rd[p])) rise_st = p;
        end
        for (int p = 0; p < 12; p++) if (a_oe[p]) oe_last = p;
        chk(fall_st - fall_ale == 3, "R3 ale fall to strobe fall", fall_st - fall_ale, 3);
        chk(rise_st - fall_st == 6, "R3 strobe width", rise_st - fall_st, 6);
        if (wr) chk(oe_last - rise_st == 0 && rise_st - 4 == 7, "R5 setup/hold window",
                    oe_last, rise_st);
        else    chk(oe_last == 3, "R4 address hold then float", oe_last, 3);
        @(negedge clk);
        chk(!busy && !done && !ale, "R10 idle after cycle", {busy, done, ale}, 0);
        chk(a_hi == addr[15:8], "R8 high address kept idle", a_hi, addr[15:8]);
        if (!wr) chk(rdata == rv, "R7 rdata holds after ad_in change", rdata, rv);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk(!busy && !ale && a_hi == addr[15:8], "R10 busy request ignored",
                    {busy, ale, a_hi}, {2'b00, addr[15:8]});
            end
        end
    endtask

    // R7: a later write must not disturb the captured read byte.
    task automatic t_read_then_write();
        t_cycle(1'b0, 16'h12C3, 8'h00, 8'h96, 1'b0);
        t_cycle(1'b1, 16'hFE01, 8'h3C, 8'h00, 1'b0);
        chk(rdata == 8'h96, "R7 rdata kept across write", rdata, 8'h96);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_cycle(1'b1, 16'hA55A, 8'hC3, 8'h00, 1'b0);   // write, mixed address
        t_cycle(1'b0, 16'h0000, 8'h00, 8'hFF, 1'b0);   // read, all-zero address
        t_cycle(1'b1, 16'hFFFF, 8'h00, 8'h00, 1'b1);   // write with busy request
        t_cycle(1'b0, 16'h80FE, 8'h00, 8'h01, 1'b1);   // read with busy request
        t_read_then_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule